// File: doc/BRIEF.md
# Three-Level Privilege Stack Controller

This block owns a 64-bit machine status register whose low part is a three-entry stack of (privilege, interrupt-enable) pairs. The stack also carries a memory-privilege-override flag, a translation-mode field and two dirty-state fields: one for floating point and one for an extension. On a trap the stack shifts one level deeper. The block records the cause and computes a vector address that depends on the privilege level that was interrupted. On a trap return the stack shifts back up.

Software writes reach the register in two ways: the full machine view, or a narrower supervisor view that touches only a subset of fields. Each field is checked before it is accepted. The supervisor view is also presented as a read port.

Trap entry, trap return and a software write are single-cycle requests. Trap entry wins over return, and return wins over a write. All results appear on registered outputs one clock after the request.

Top module: `prv_stack_ctrl`

## Requirements
- R1: After reset, the status register reads as follows: current privilege 3, both stacked privileges 1, all enables 0, override 0, dirty fields 0, mode 0. The target reads base+0x100, and the cause reads 0.
- R2: A trap moves level 1 into level 2 and the current pair into level 1. It then sets the current privilege to 3 and clears the current enable and the override bit.
- R3: On a trap, the target becomes base + 0x40 × the current privilege held before the trap.
- R4: The cause output takes the trap cause input on a trap and holds its value otherwise.
- R5: A trap return moves level 1 into the current pair and level 2 into level 1, then sets level 2 to privilege 0 with enable 1.
- R6: Trap entry takes precedence over trap return, and trap return takes precedence over a software write issued in the same cycle.
- R7: Machine status layout: enable0 bit 0, privilege0 bits 2:1, enable1 bit 3, privilege1 bits 5:4, enable2 bit 6, privilege2 bits 8:7, override bit 9, float state bits 11:10, extension state bits 13:12, mode bits 18:14. A machine write stores the enables, override and dirty fields. Each privilege field is stored only if the written value is not 2.
- R8: The mode field accepts 0 (bare). With a 64-bit width it also accepts 9 or 10; with a 32-bit width it also accepts 8. Any other value leaves the mode unchanged.
- R9: Bit 63 reads 1 exactly when the float state or the extension state equals 3. Writes to bit 63 and to bits 62:19 have no effect, and those bits read 0.
- R10: The supervisor view puts current enable at bit 0, level-1 enable at bit 1, bit 0 of the level-1 privilege at bit 2, override at bit 3, float state at bits 5:4 and extension state at bits 7:6. Bit 63 is the summary dirty bit, and all other bits read 0.
- R11: A supervisor write maps those same fields onto the machine fields. The level-1 privilege becomes {0, bit 2}. Current privilege, level 2 and mode are unchanged.
- R12: In a cycle with no trap, no return and no write, the status, target and cause hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Trap entry pulse |
| trap_cause_i | input | CAUSE_W | Cause code for the trap |
| trap_ret_i | input | 1 | Trap return pulse |
| csr_wr_i | input | 1 | Software write strobe |
| csr_sup_i | input | 1 | 1: write uses the supervisor view, 0: machine view |
| csr_wdata_i | input | 64 | Write data |
| status_o | output | 64 | Machine status view |
| sup_status_o | output | 64 | Supervisor status view |
| cause_o | output | CAUSE_W | Latched trap cause |
| target_o | output | ADDR_W | Trap or start target address |

## Verification
On every cycle, the assertions check the push and pop shift patterns and the vector offset for each trap. They also check that the cause is captured, that no privilege field ever holds the reserved value 2, that the mode field always holds a legal value, and that the register stays quiet when no request is present. Only the bench scenarios can show the following: field-level masking of illegal privilege and mode values within a single write, the mapping between the supervisor view and the machine fields in both directions, the dirty summary bit, and precedence when requests collide.

// File: rtl/prv_stack_pkg.sv
package prv_stack_pkg;

  localparam int STAT_W = 64;

  localparam logic [1:0] PRV_USER  = 2'd0;
  localparam logic [1:0] PRV_SUPER = 2'd1;
  localparam logic [1:0] PRV_RSVD  = 2'd2;
  localparam logic [1:0] PRV_MACH  = 2'd3;

  localparam logic [4:0] MODE_BARE = 5'd0;
  localparam logic [4:0] MODE_PG32 = 5'd8;
  localparam logic [4:0] MODE_PG39 = 5'd9;
  localparam logic [4:0] MODE_PG48 = 5'd10;

  // supervisor view bit positions
  localparam int S_IE  = 0;
  localparam int S_PIE = 1;
  localparam int S_PS  = 2;
  localparam int S_OVR = 3;
  localparam int S_FS  = 4;
  localparam int S_XS  = 6;

  typedef struct packed {
    logic [1:0] prv;
    logic       ie;
  } lvl_t;

  typedef struct packed {
    logic [4:0] mode;
    logic [1:0] xs;
    logic [1:0] fs;
    logic       ovr;
    lvl_t [2:0] stk;
  } stat_t;

  localparam int STAT_BITS = $bits(stat_t);

  function automatic logic mode_ok(input logic [4:0] m, input int xl);
    return (m == MODE_BARE) ||
           (xl == 32 && m == MODE_PG32) ||
           (xl == 64 && (m == MODE_PG39 || m == MODE_PG48));
  endfunction

endpackage

// File: rtl/prv_stack_shift.sv
module prv_stack_shift
  import prv_stack_pkg::*;
(
  input  stat_t cur_i,
  input  logic  push_i,
  output stat_t nxt_o
);

  lvl_t up [3];
  lvl_t dn [3];

  assign up[0] = '{prv: PRV_MACH, ie: 1'b0};
  assign dn[2] = '{prv: PRV_USER, ie: 1'b1};

  for (genvar i = 1; i < 3; i++) begin : g_up
    assign up[i] = cur_i.stk[i-1];
  end

  for (genvar i = 0; i < 2; i++) begin : g_dn
    assign dn[i] = cur_i.stk[i+1];
  end

  always_comb begin
    nxt_o = cur_i;
    for (int i = 0; i < 3; i++) begin
      nxt_o.stk[i] = push_i ? up[i] : dn[i];
    end
    if (push_i) nxt_o.ovr = 1'b0;
  end

endmodule

// File: rtl/prv_field_filter.sv
module prv_field_filter
  import prv_stack_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  stat_t              cur_i,
  input  logic [STAT_W-1:0]  wdata_i,
  input  logic               sup_i,
  output stat_t              nxt_o
);

  stat_t offer;
  logic  unused_hi;

  assign unused_hi = ^wdata_i[STAT_W-1:STAT_BITS];

  always_comb begin
    if (sup_i) begin
      offer            = cur_i;
      offer.stk[0].ie  = wdata_i[S_IE];
      offer.stk[1].ie  = wdata_i[S_PIE];
      offer.stk[1].prv = {1'b0, wdata_i[S_PS]};
      offer.ovr        = wdata_i[S_OVR];
      offer.fs         = wdata_i[S_FS +: 2];
      offer.xs         = wdata_i[S_XS +: 2];
    end else begin
      offer = stat_t'(wdata_i[STAT_BITS-1:0]);
    end
  end

  always_comb begin
    nxt_o     = offer;
    for (int i = 0; i < 3; i++) begin
      if (offer.stk[i].prv == PRV_RSVD) nxt_o.stk[i].prv = cur_i.stk[i].prv;
    end
    nxt_o.mode = mode_ok(offer.mode, XLEN) ? offer.mode : cur_i.mode;
  end

endmodule

// File: rtl/prv_vector_gen.sv
module prv_vector_gen #(
  parameter int              ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h1000
) (
  input  logic [1:0]        prv_i,
  output logic [ADDR_W-1:0] tgt_o
);

  localparam int STRIDE_SH = 6;

  assign tgt_o = VEC_BASE + ADDR_W'({prv_i, {STRIDE_SH{1'b0}}});

endmodule

// File: rtl/prv_stack_ctrl.sv
module prv_stack_ctrl
  import prv_stack_pkg::*;
#(
  parameter int                XLEN     = 64,
  parameter int                CAUSE_W  = 64,
  parameter int                ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic               trap_ret_i,
  input  logic               csr_wr_i,
  input  logic               csr_sup_i,
  input  logic [STAT_W-1:0]  csr_wdata_i,
  output logic [STAT_W-1:0]  status_o,
  output logic [STAT_W-1:0]  sup_status_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ADDR_W-1:0]  target_o
);

  localparam logic [ADDR_W-1:0] BOOT_ADDR = VEC_BASE + ADDR_W'(256);
  localparam stat_t STAT_RST = '{mode: MODE_BARE, xs: 2'd0, fs: 2'd0, ovr: 1'b0,
                                 stk: {{PRV_SUPER, 1'b0}, {PRV_SUPER, 1'b0}, {PRV_MACH, 1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  stat_t              stat_q, stat_d, shift_nxt, filt_nxt;
  logic               stat_en;
  logic [ADDR_W-1:0]  tgt_q, tgt_d;
  logic [CAUSE_W-1:0] cause_q;
  logic               sd;

  prv_stack_shift u_shift (
    .cur_i  (stat_q),
    .push_i (trap_i),
    .nxt_o  (shift_nxt)
  );

  prv_field_filter #(.XLEN(XLEN)) u_filter (
    .cur_i   (stat_q),
    .wdata_i (csr_wdata_i),
    .sup_i   (csr_sup_i),
    .nxt_o   (filt_nxt)
  );

  prv_vector_gen #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
    .prv_i (stat_q.stk[0].prv),
    .tgt_o (tgt_d)
  );

  // next state
  always_comb begin
    stat_en = trap_i | trap_ret_i | csr_wr_i;
    stat_d  = (trap_i | trap_ret_i) ? shift_nxt : filt_nxt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     stat_q <= STAT_RST;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    tgt_q <= BOOT_ADDR;
    else if (trap_i) tgt_q <= tgt_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cause_q <= '0;
    else if (trap_i) cause_q <= trap_cause_i;
  end

  // views
  always_comb begin
    sd                   = (stat_q.fs == 2'b11) | (stat_q.xs == 2'b11);
    status_o             = {sd, {(STAT_W-1-STAT_BITS){1'b0}}, stat_q};
    sup_status_o         = '0;
    sup_status_o[S_IE]   = stat_q.stk[0].ie;
    sup_status_o[S_PIE]  = stat_q.stk[1].ie;
    sup_status_o[S_PS]   = stat_q.stk[1].prv[0];
    sup_status_o[S_OVR]  = stat_q.ovr;
    sup_status_o[S_FS +: 2] = stat_q.fs;
    sup_status_o[S_XS +: 2] = stat_q.xs;
    sup_status_o[STAT_W-1]  = sd;
  end

  assign cause_o  = cause_q;
  assign target_o = tgt_q;

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_i |=> (stat_q.stk[0].prv == PRV_MACH) && !stat_q.stk[0].ie && !stat_q.ovr &&
               (stat_q.stk[1] == $past(stat_q.stk[0])) &&
               (stat_q.stk[2] == $past(stat_q.stk[1])));

  // R5
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_ret_i && !trap_i) |=> (stat_q.stk[0] == $past(stat_q.stk[1])) &&
                                (stat_q.stk[1] == $past(stat_q.stk[2])) &&
                                (stat_q.stk[2].prv == PRV_USER) && stat_q.stk[2].ie);

  // R3
  vec_offset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_i |=> target_o == VEC_BASE + ADDR_W'($past(stat_q.stk[0].prv)) * ADDR_W'(64));

  // R4
  cause_latch_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_i |=> cause_o == $past(trap_cause_i));

  // R7
  no_rsvd_prv_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status_o[2:1] != PRV_RSVD) && (status_o[5:4] != PRV_RSVD) && (status_o[8:7] != PRV_RSVD));

  // R8
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_ok(status_o[18:14], XLEN));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!trap_i && !trap_ret_i && !csr_wr_i) |=> $stable(status_o) && $stable(target_o) && $stable(cause_o));

endmodule

// File: tb/test_prv_stack_ctrl.sv
module test_prv_stack_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 1'b0;
  logic [63:0] trap_cause_i = '0;
  logic        trap_ret_i = 1'b0;
  logic        csr_wr_i = 1'b0;
  logic        csr_sup_i = 1'b0;
  logic [63:0] csr_wdata_i = '0;
  logic [63:0] status_o, sup_status_o, cause_o, target_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  prv_stack_ctrl i_prv_stack_ctrl (
    .clk, .rst_n, .trap_i, .trap_cause_i, .trap_ret_i, .csr_wr_i, .csr_sup_i,
    .csr_wdata_i, .status_o, .sup_status_o, .cause_o, .target_o
  );

  // machine layout per R7
  function automatic logic [63:0] mst(input logic [1:0] p0, input logic i0,
                                      input logic [1:0] p1, input logic i1,
                                      input logic [1:0] p2, input logic i2,
                                      input logic ov, input logic [1:0] fs,
                                      input logic [1:0] xs, input logic [4:0] md);
    return {45'b0, md, xs, fs, ov, p2, i2, p1, i1, p0, i0};
  endfunction

  // supervisor layout per R10
  function automatic logic [63:0] sst(input logic ie, input logic pie, input logic ps,
                                      input logic ov, input logic [1:0] fs, input logic [1:0] xs);
    return {56'b0, xs, fs, ov, ps, pie, ie};
  endfunction

  function automatic logic [63:0] with_sd(input logic [63:0] s);
    logic [63:0] r = s;
    r[63] = (s[11:10] == 2'b11) || (s[13:12] == 2'b11);
    return r;
  endfunction

  function automatic logic [63:0] sup_of(input logic [63:0] s);
    logic [63:0] r = sst(s[0], s[3], s[4], s[9], s[11:10], s[13:12]);
    r[63] = s[63];
    return r;
  endfunction

  // op: [3] trap, [2] return, [1] write, [0] supervisor view
  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] data;
    logic [63:0] cause;
    logic [63:0] est;
    logic [63:0] etgt;
    logic [63:0] ecause;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    // R7 legal machine write
    '{4'h2, mst(0,1,1,1,0,1,1,1,0,9), 64'hDEAD, mst(0,1,1,1,0,1,1,1,0,9), 64'h1100, 64'h0},
    // R2 R3 trap from user
    '{4'h8, 64'h0, 64'd5, mst(3,0,0,1,1,1,0,1,0,9), 64'h1000, 64'd5},
    // R2 R3 trap from machine
    '{4'h8, 64'h0, 64'd7, mst(3,0,3,0,0,1,0,1,0,9), 64'h10C0, 64'd7},
    // R5 returns
    '{4'h4, 64'h0, 64'hBEEF, mst(3,0,0,1,0,1,0,1,0,9), 64'h10C0, 64'd7},
    '{4'h4, 64'h0, 64'hBEEF, mst(0,1,0,1,0,1,0,1,0,9), 64'h10C0, 64'd7},
    // R7 R8 reserved privilege and illegal mode kept
    '{4'h2, mst(2,0,1,0,2,0,0,3,0,8), 64'h0, mst(0,0,1,0,0,0,0,3,0,9), 64'h10C0, 64'd7},
    // R9 bits 63 and 40 ignored
    '{4'h2, mst(1,1,3,1,3,0,1,0,3,10) | 64'h8000_0100_0000_0000, 64'h0,
            mst(1,1,3,1,3,0,1,0,3,10), 64'h10C0, 64'd7},
    // R3 trap from supervisor
    '{4'h8, 64'h0, 64'd2, mst(3,0,1,1,3,1,0,0,3,10), 64'h1040, 64'd2},
    // R11 supervisor write
    '{4'h3, sst(1,0,0,1,2,1), 64'h0, mst(3,1,0,0,3,1,1,2,1,10), 64'h1040, 64'd2},
    // R8 back to bare
    '{4'h2, mst(3,0,3,0,1,0,0,0,0,0), 64'h0, mst(3,0,3,0,1,0,0,0,0,0), 64'h1040, 64'd2},
    // R11 previous-privilege upper bit cleared
    '{4'h3, sst(0,0,1,0,0,0), 64'h0, mst(3,0,1,0,1,0,0,0,0,0), 64'h1040, 64'd2},
    // R6 trap beats return and write
    '{4'hE, mst(0,1,0,1,0,1,1,3,3,0), 64'd9, mst(3,0,3,0,1,0,0,0,0,0), 64'h10C0, 64'd9},
    // R6 return beats write
    '{4'h6, mst(0,1,0,1,0,1,1,3,3,0), 64'h0, mst(3,0,1,0,0,1,0,0,0,0), 64'h10C0, 64'd9},
    // R12 idle with busy data lines
    '{4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h33, mst(3,0,1,0,0,1,0,0,0,0), 64'h10C0, 64'd9},
    // R9 R11 dirty via supervisor write
    '{4'h3, sst(1,1,1,1,3,3), 64'h0, mst(3,1,1,1,0,1,1,3,3,0), 64'h10C0, 64'd9}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [63:0] est,
                           input logic [63:0] etgt, input logic [63:0] ecause);
    chk({tag, " status"}, status_o, with_sd(est));
    chk({tag, " R3 target"}, target_o, etgt);
    chk({tag, " R4 cause"}, cause_o, ecause);
    chk({tag, " R10 sup view"}, sup_status_o, sup_of(with_sd(est)));
  endtask

  task automatic apply(input logic [3:0] op, input logic [63:0] d, input logic [63:0] c);
    @(negedge clk);
    trap_i       = op[3];
    trap_ret_i   = op[2];
    csr_wr_i     = op[1];
    csr_sup_i    = op[0];
    csr_wdata_i  = d;
    trap_cause_i = c;
    @(negedge clk);
    trap_i = 1'b0; trap_ret_i = 1'b0; csr_wr_i = 1'b0; csr_sup_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check_all("R1", mst(3,0,1,0,1,0,0,0,0,0), 64'h1100, 64'h0);

    for (int k = 0; k < NV; k++) begin
      apply(VT[k].op, VT[k].data, VT[k].cause);
      check_all($sformatf("vec%0d", k), VT[k].est, VT[k].etgt, VT[k].ecause);
    end

    // R8 mode 8 rejected at 64-bit width, from bare
    apply(4'h2, mst(3,0,1,0,1,0,0,0,0,8), 64'h0);
    chk("R8 mode8", status_o, mst(3,0,1,0,1,0,0,0,0,0));
    // R8 mode 10 then an undefined value 31
    apply(4'h2, mst(3,0,1,0,1,0,0,0,0,10), 64'h0);
    apply(4'h2, mst(3,0,1,0,1,0,0,0,0,31), 64'h0);
    chk("R8 mode31", status_o, mst(3,0,1,0,1,0,0,0,0,10));
    // R2 R5 double push then double pop restores level pairs
    apply(4'h8, 64'h0, 64'd4);
    apply(4'h8, 64'h0, 64'd6);
    chk("R2 double push", status_o, mst(3,0,3,0,3,0,0,0,0,10));
    chk("R3 machine vector", target_o, 64'h10C0);
    apply(4'h4, 64'h0, 64'h0);
    apply(4'h4, 64'h0, 64'h0);
    chk("R5 double pop", status_o, mst(3,0,0,1,0,1,0,0,0,10));

    // R1 reset mid-run
    do_reset();
    check_all("R1 again", mst(3,0,1,0,1,0,0,0,0,0), 64'h1100, 64'h0);

    done = 1;
    finish_run();
  end

endmodule